// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block gives a processor control over a group of up to 32 general-purpose pins through a small word-register bus. Software picks, pin by pin, whether the bank drives the pin or only samples it. It sets the levels the bank drives and reads back the synchronised level of every pin. It chooses which pins may raise the single interrupt line toward the processor.

The trigger condition is fixed when the block is built, through a parameter. In the three edge modes (rising, falling, either), a detected edge latches a sticky per-pin event bit, and software acknowledges it by writing ones. In level mode no event bits exist, and the interrupt follows the masked synchronised pin levels directly. Pin inputs pass through a two-stage synchroniser before any use. Edges are found by comparing each synchronised sample with the one taken a clock earlier.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero), `pin_out` is zero, the enable and event registers read zero, `bus_rvalid` is low and `irq` is low.
- R2: Registers sit at byte addresses 0x0 (pin level / output latch), 0x4 (direction), 0x8 (interrupt enable) and 0xC (event). A read request returns its data with `bus_rvalid` high in the cycle after the request. Any other address reads zero and a write to it changes nothing.
- R3: Bits at and above `NUM_PINS` read as zero in every register and ignore writes. Pins above `NUM_PINS` do not exist.
- R4: A direction bit of 1 makes the pin an output. `pin_oe` equals the direction register, and `pin_out` shows the output latch on output pins and 0 on input pins.
- R5: A read at 0x0 returns the level of every pin, whatever its direction, two clock edges after the pin changes.
- R6: In an edge mode, an event bit is set by the selected edge only. In rising mode only 0-to-1 transitions count, in falling mode only 1-to-0, and in both-edge mode either. The bit is set on the third clock edge after the pin changes.
- R7: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged, and event bits never clear by themselves.
- R8: When an edge is detected in the same cycle as a clearing write to that bit, the bit stays set.
- R9: In an edge mode, `irq` is high exactly while some event bit is set whose enable bit is also 1.
- R10: In level mode, `irq` is high while some synchronised pin level is 1 with its enable bit set, two clock edges after the pin changes. The event register reads zero in this mode.
- R11: `NUM_PINS` must lie between 1 and 32; any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Levels to drive onto output pins |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds three copies on one shared bus and pin stimulus. The first is a 12-pin rising-edge bank, so the zero-reading upper bits and the ignoring of pins beyond the width can be observed. The second is a full 32-pin both-edge bank, which shows falling and rising events side by side and exercises the widest register. The third is an 8-pin level-mode bank. Together they make the mode-specific edge selection, the level interrupt latency and the clear-versus-new-edge collision visible at the ports under identical stimulus.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int MAX_PINS = 32;
   localparam int BUS_W    = 32;
   localparam int ADDR_W   = 4;

   typedef enum logic [1:0] {
      TRIG_RISE  = 2'd0,
      TRIG_FALL  = 2'd1,
      TRIG_BOTH  = 2'd2,
      TRIG_LEVEL = 2'd3
   } trig_e;

   localparam logic [ADDR_W-1:0] ADR_LEVEL  = 4'h0;
   localparam logic [ADDR_W-1:0] ADR_DIR    = 4'h4;
   localparam logic [ADDR_W-1:0] ADR_ENABLE = 4'h8;
   localparam logic [ADDR_W-1:0] ADR_EVENT  = 4'hC;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_in,
   output logic [W-1:0] sync_out
);
   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else begin
               stage_q[s] <= (s == 0) ? raw_in : stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_event.sv
module gpio_event
   import gpio_bank_pkg::*;
#(
   parameter int    W    = 32,
   parameter trig_e TRIG = TRIG_RISE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   input  logic [W-1:0] enable,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] evt_q,
   output logic         irq
);
   generate
      if (TRIG == TRIG_LEVEL) begin : g_level
         assign evt_q = '0;
         assign irq   = |(level & enable);
      end else begin : g_edge
         logic [W-1:0] prev_q;
         logic [W-1:0] hit;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= '0;
            end else begin
               prev_q <= level;
            end
         end

         if (TRIG == TRIG_RISE) begin : g_rise
            assign hit = level & ~prev_q;
         end else if (TRIG == TRIG_FALL) begin : g_fall
            assign hit = ~level & prev_q;
         end else begin : g_both
            assign hit = level ^ prev_q;
         end

         // a fresh edge outranks a clear arriving in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               evt_q <= '0;
            end else begin
               evt_q <= (evt_q & ~clr_bits) | hit;
            end
         end

         assign irq = |(evt_q & enable);
      end
   endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_bank_pkg::*;
#(
   parameter int W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              bus_rvalid,
   input  logic [W-1:0]      level,
   input  logic [W-1:0]      evt,
   output logic [W-1:0]      out_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      enable_q,
   output logic [W-1:0]      clr_bits
);
   logic             wr_req;
   logic             rd_req;
   logic [W-1:0]     wbits;
   logic [W-1:0]     rd_sel;
   logic [BUS_W-1:0] rd_word;

   assign wr_req = bus_valid &  bus_write;
   assign rd_req = bus_valid & ~bus_write;
   assign wbits  = bus_wdata[W-1:0];

   assign clr_bits = (wr_req && bus_addr == ADR_EVENT) ? wbits : '0;

   always_comb begin
      unique case (bus_addr)
         ADR_LEVEL:  rd_sel = level;
         ADR_DIR:    rd_sel = dir_q;
         ADR_ENABLE: rd_sel = enable_q;
         ADR_EVENT:  rd_sel = evt;
         default:    rd_sel = '0;
      endcase
      rd_word        = '0;
      rd_word[W-1:0] = rd_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q      <= '0;
         dir_q      <= '0;
         enable_q   <= '0;
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd_req;
         if (rd_req) begin
            bus_rdata <= rd_word;
         end
         if (wr_req) begin
            unique case (bus_addr)
               ADR_LEVEL:  out_q    <= wbits;
               ADR_DIR:    dir_q    <= wbits;
               ADR_ENABLE: enable_q <= wbits;
               default:    ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int    NUM_PINS = 32,
   parameter trig_e TRIG     = TRIG_RISE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic [3:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                bus_rvalid,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq
);
   localparam int SYNC_STAGES = 2;

   // R11: width check at elaboration
   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_width
      $error("gpio_bank: NUM_PINS must be within 1..32");
   end

   logic [NUM_PINS-1:0] level_q;
   logic [NUM_PINS-1:0] out_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] mask_q;
   logic [NUM_PINS-1:0] cap_q;
   logic [NUM_PINS-1:0] clr_bits;

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (pin_in),
      .sync_out (level_q)
   );

   gpio_regs #(.W(NUM_PINS)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_valid  (bus_valid),
      .bus_write  (bus_write),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .level      (level_q),
      .evt        (cap_q),
      .out_q      (out_q),
      .dir_q      (dir_q),
      .enable_q   (mask_q),
      .clr_bits   (clr_bits)
   );

   gpio_event #(.W(NUM_PINS), .TRIG(TRIG)) u_event (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (level_q),
      .enable   (mask_q),
      .clr_bits (clr_bits),
      .evt_q    (cap_q),
      .irq      (irq)
   );

   assign pin_oe  = dir_q;
   assign pin_out = out_q & dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int NUM_PINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_valid,
   input logic                bus_write,
   input logic [3:0]          bus_addr,
   input logic [31:0]         bus_rdata,
   input logic                bus_rvalid,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] cap_q,
   input logic [NUM_PINS-1:0] mask_q,
   input logic                irq
);
   localparam logic [31:0] PIN_BITS =
      (NUM_PINS >= 32) ? 32'hFFFF_FFFF : ((32'h1 << NUM_PINS) - 32'h1);

   logic rd_req;
   logic clr_wr;
   logic dir_wr;
   assign rd_req = bus_valid && !bus_write;
   assign clr_wr = bus_valid && bus_write && bus_addr == 4'hC;
   assign dir_wr = bus_valid && bus_write && bus_addr == 4'h4;

   assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> bus_rvalid);

   assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !bus_rvalid);

   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> (bus_rdata & ~PIN_BITS) == 32'h0);

   assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_wr |=> $stable(pin_oe));

   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (cap_q & $past(cap_q)) == $past(cap_q));

   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_write  (bus_write),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .pin_oe     (pin_oe),
   .cap_q      (cap_q),
   .mask_q     (mask_q),
   .irq        (irq)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
   import gpio_bank_pkg::*;

   localparam int NA = 12;
   localparam int NB = 32;
   localparam int NC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] pins = '0;

   logic [31:0] rd_a, rd_b, rd_c;
   logic        rv_a, rv_b, rv_c;
   logic [NA-1:0] out_a, oe_a;
   logic [NB-1:0] out_b, oe_b;
   logic [NC-1:0] out_c, oe_c;
   logic irq_a, irq_b, irq_c;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_bank #(.NUM_PINS(NA), .TRIG(TRIG_RISE)) dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a), .bus_rvalid(rv_a),
      .pin_in(pins[NA-1:0]), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

   gpio_bank #(.NUM_PINS(NB), .TRIG(TRIG_BOTH)) dut_both (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b), .bus_rvalid(rv_b),
      .pin_in(pins[NB-1:0]), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

   gpio_bank #(.NUM_PINS(NC), .TRIG(TRIG_LEVEL)) dut_lvl (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_c), .bus_rvalid(rv_c),
      .pin_in(pins[NC-1:0]), .pin_out(out_c), .pin_oe(oe_c), .irq(irq_c));

   typedef struct packed {
      logic        wr;
      logic [3:0]  addr;
      logic [31:0] wd;
      logic [31:0] ea;
      logic [31:0] eb;
      logic [31:0] ec;
   } vec_t;

   // register walk: expected values per bank width (12 / 32 / 8 pins)
   localparam vec_t VEC [11] = '{
      '{1'b1, 4'h4, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0},
      '{1'b0, 4'h4, 32'h0, 32'h0000_0FFF, 32'hFFFF_FFFF, 32'h0000_00FF},
      '{1'b1, 4'h8, 32'hA5A5_A5A5, 32'h0, 32'h0, 32'h0},
      '{1'b0, 4'h8, 32'h0, 32'h0000_05A5, 32'hA5A5_A5A5, 32'h0000_00A5},
      '{1'b1, 4'h4, 32'h0, 32'h0, 32'h0, 32'h0},
      '{1'b0, 4'h4, 32'h0, 32'h0, 32'h0, 32'h0},
      '{1'b1, 4'h8, 32'h0, 32'h0, 32'h0, 32'h0},
      '{1'b0, 4'h8, 32'h0, 32'h0, 32'h0, 32'h0},
      '{1'b0, 4'hC, 32'h0, 32'h0, 32'h0, 32'h0},
      '{1'b1, 4'h2, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0},
      '{1'b0, 4'h2, 32'h0, 32'h0, 32'h0, 32'h0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, input logic [31:0] ea, input logic [31:0] eb,
                         input logic [31:0] ec, input string req);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 1'b0;
      check({req, " rvalid"}, {29'd0, rv_a, rv_b, rv_c}, 32'h7);
      check({req, " bank12"}, rd_a, ea);
      check({req, " bank32"}, rd_b, eb);
      check({req, " bank8"},  rd_c, ec);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(3);
      // R1: state while and after reset
      check("R1 oe", {oe_a, oe_b[19:0]}, 32'h0);
      check("R1 out", {out_a, out_b[19:0]}, 32'h0);
      check("R1 irq", {29'd0, irq_a, irq_b, irq_c}, 32'h0);
      rst_n = 1'b1;
      tick(1);
      check("R1 R2 rvalid idle", {29'd0, rv_a, rv_b, rv_c}, 32'h0);
      bus_rd(4'h4, 0, 0, 0, "R1 dir");
      bus_rd(4'h8, 0, 0, 0, "R1 enable");
      bus_rd(4'hC, 0, 0, 0, "R1 event");

      // R2 R3: table walk over register map and width limits
      for (int i = 0; i < 11; i++) begin
         if (VEC[i].wr) bus_wr(VEC[i].addr, VEC[i].wd);
         else bus_rd(VEC[i].addr, VEC[i].ea, VEC[i].eb, VEC[i].ec, "R2 R3 table");
      end

      // R4: direction and output latch
      bus_wr(4'h4, 32'h0000_000F);
      bus_wr(4'h0, 32'hFFFF_FABC);
      check("R4 oe12", {20'd0, oe_a}, 32'h0000_000F);
      check("R4 out12", {20'd0, out_a}, 32'h0000_000C);
      check("R4 out32", out_b, 32'h0000_000C);
      bus_wr(4'h4, 32'h0);
      check("R4 out off", out_b, 32'h0);

      // R5: pin level readback after two edges
      pins = 32'h8000_05A3;
      tick(2);
      bus_rd(4'h0, 32'h0000_05A3, 32'h8000_05A3, 32'h0000_00A3, "R5 level");
      pins = 32'h0;
      tick(3);
      bus_wr(4'hC, 32'hFFFF_FFFF);
      bus_rd(4'hC, 0, 0, 0, "R7 clear all");

      // R6 R9 R10: event capture and interrupt timing
      bus_wr(4'h8, 32'hFFFF_FFFF);
      check("R9 R10 irq idle", {29'd0, irq_a, irq_b, irq_c}, 32'h0);
      pins = 32'h0000_0011;
      tick(2);
      check("R10 level irq after 2", {31'd0, irq_c}, 32'h1);
      check("R6 no event yet", {30'd0, irq_a, irq_b}, 32'h0);
      tick(1);
      check("R6 R9 irq after 3", {30'd0, irq_a, irq_b}, 32'h3);
      bus_rd(4'hC, 32'h11, 32'h11, 32'h0, "R6 R10 rising");

      // R7: write-zero keeps, write-one clears
      bus_wr(4'hC, 32'h0);
      bus_rd(4'hC, 32'h11, 32'h11, 32'h0, "R7 write zero");
      bus_wr(4'hC, 32'h1);
      bus_rd(4'hC, 32'h10, 32'h10, 32'h0, "R7 write one");

      // R6: falling edges count only in both-edge mode
      pins = 32'h0;
      tick(3);
      check("R10 level irq low", {31'd0, irq_c}, 32'h0);
      bus_rd(4'hC, 32'h10, 32'h11, 32'h0, "R6 falling");

      // R9: enable gating
      bus_wr(4'h8, 32'h1);
      check("R9 gated", {30'd0, irq_a, irq_b}, 32'h1);
      bus_wr(4'h8, 32'h0);
      check("R9 all masked", {30'd0, irq_a, irq_b}, 32'h0);
      bus_wr(4'hC, 32'hFFFF_FFFF);
      bus_wr(4'h8, 32'hFFFF_FFFF);

      // R8: edge coincides with clearing write
      pins = 32'h2;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'hC; bus_wdata = 32'h2;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      bus_rd(4'hC, 32'h2, 32'h2, 32'h0, "R8 edge wins");

      // R3: pin beyond the 12-pin bank
      pins = 32'h0010_0000;
      tick(3);
      bus_rd(4'hC, 32'h2, 32'h0010_0002, 32'h0, "R3 missing pin");
      bus_rd(4'h0, 32'h0, 32'h0010_0000, 32'h0, "R3 level");

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule